// File: doc/BRIEF.md
# Seven-slot pixel serializer for flat-panel links

This block turns one parallel pixel per pixel clock into a serial stream: three or four data lanes plus a clock lane, each carrying seven bit-slots per pixel period. A pixel holds 8-bit red, green and blue values and the three control bits horizontal sync, vertical sync and data enable. A two-bit mode input, sampled along with each pixel, picks one of three color-to-slot layouts: an 18-bit layout on three lanes and two 24-bit layouts on four lanes.

The pixel is sampled into a holding register on every rising edge of the pixel clock. At the next pixel boundary that register is turned into a frame of seven slots per lane in the bit-clock domain. The bit clock runs at seven times the pixel rate and is phase-locked to the pixel clock, with every seventh rising edge lined up with a rising pixel edge. Both clocks come from outside the block. The lanes are single-ended, registered bits meant to feed differential output stages.

Top module: `lvds_pixel_serializer`

## Requirements
- R1: While reset is low, and afterwards until the first pixel boundary after reset, all four data lanes and the clock lane are 0.
- R2: Once running, the clock lane shows 1,1,0,0,0,1,1 in slots 0 to 6 of every pixel period.
- R3: With mode 0 (and also mode 3), lane 0 carries G0,R5,R4,R3,R2,R1,R0 and lane 1 carries B1,B0,G5,G4,G3,G2,G1 in slots 0 to 6. Lane 2 carries DE,VS,HS,B5,B4,B3,B2.
- R4: With mode 0 or 3, lane 3 stays 0 in every slot.
- R5: With mode 1, lane 0 is G2,R7..R2 and lane 1 is B3,B2,G7..G3. Lane 2 is DE,VS,HS,B7..B4 and lane 3 is 0,B1,B0,G1,G0,R1,R0, all listed in slot order 0 to 6.
- R6: With mode 2, lanes 0 to 2 match R3 and lane 3 is 0,B7,B6,G7,G6,R7,R6 in slots 0 to 6.
- R7: Slot 0 of lane 2 is data enable, slot 1 is vertical sync and slot 2 is horizontal sync. Slot 0 of lane 3 is 0 in every mode.
- R8: A pixel sampled at a rising pixel-clock edge is sent during the next pixel period. Its slot s appears on the lanes after the (s+1)-th rising bit-clock edge, counting the bit edge that lines up with the next pixel edge as the first.
- R9: The mode is sampled with the pixel at the pixel-clock edge. Changes on the mode or pixel inputs between pixel edges have no effect, and every pixel period uses exactly one layout.
- R10: A synchronous reset in the middle of a run drives all lanes low. Once reset is released on a pixel boundary, the slot sequence starts again at slot 0, seven bit edges after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit-slot clock at seven times the pixel rate |
| pix_clk | input | 1 | Pixel clock, rising edge lined up with every seventh bit edge |
| rst_n | input | 1 | Synchronous active-low reset, sampled in both clock domains |
| red_i | input | 8 | Red component |
| green_i | input | 8 | Green component |
| blue_i | input | 8 | Blue component |
| hsync_i | input | 1 | Horizontal sync |
| vsync_i | input | 1 | Vertical sync |
| de_i | input | 1 | Data enable |
| mode_i | input | 2 | Layout select: 0 or 3 narrow, 1 wide with MSBs on lanes 0-2, 2 wide with MSBs on lane 3 |
| lane_o | output | 4 | Serial data lanes, bit i is lane i |
| clk_lane_o | output | 1 | Serial clock-lane pattern |

## Verification
The edge where the bit domain loads the previous pixel is the same edge where the pixel domain samples the next pixel and its mode. The bench switches the mode on every pixel and also changes the inputs between pixel edges, so a design that reads the live inputs at the load would send a pixel with its neighbour's layout. A behavioural model pops the previous pixel from a queue before it pushes the new one at that shared edge, and the bench compares all five lanes on every bit period against the model. A reset in the middle of a run is also released on that shared edge, and the bench checks that the clock-lane pattern starts again from slot 0.

// File: rtl/lvds_ser_pkg.sv
`timescale 1ns/100ps
// Shared constants, types and the slot-layout function for the serializer.
// Assumes 8-bit color components and seven slots per pixel period.
package lvds_ser_pkg;

    localparam int COLOR_W    = 8;
    localparam int SLOTS      = 7;
    localparam int DATA_LANES = 4;
    localparam int SLOT_W     = $clog2(SLOTS);

    // Clock-lane level per slot, bit s is slot s.
    localparam logic [SLOTS-1:0] CLK_PATTERN = 7'b1100011;

    typedef enum logic [1:0] {
        MAP_NARROW     = 2'd0,
        MAP_WIDE_MSB   = 2'd1,
        MAP_WIDE_EXT   = 2'd2,
        MAP_NARROW_ALT = 2'd3
    } map_e;

    typedef struct packed {
        logic [COLOR_W-1:0] red;
        logic [COLOR_W-1:0] green;
        logic [COLOR_W-1:0] blue;
        logic               hsync;
        logic               vsync;
        logic               den;
    } pixel_t;

    typedef struct packed {
        pixel_t px;
        map_e   map;
    } held_t;

    // Frame: [lane][slot], slot 0 leaves first.
    typedef logic [DATA_LANES-1:0][SLOTS-1:0] frame_t;

    // Rotate a component down by two so bit k becomes bit k+2 of the input.
    function automatic logic [COLOR_W-1:0] rot_two(input logic [COLOR_W-1:0] c);
        return {c[1:0], c[COLOR_W-1:2]};
    endfunction

    function automatic logic uses_three_lanes(input map_e m);
        return (m == MAP_NARROW) || (m == MAP_NARROW_ALT);
    endfunction

    // Build the slot layout for one held pixel. The MSB-first wide layout is
    // the extended layout applied to components rotated by two bits.
    function automatic frame_t build_frame(input held_t h);
        frame_t             f;
        logic [COLOR_W-1:0] r;
        logic [COLOR_W-1:0] g;
        logic [COLOR_W-1:0] b;
        if (h.map == MAP_WIDE_MSB) begin
            r = rot_two(h.px.red);
            g = rot_two(h.px.green);
            b = rot_two(h.px.blue);
        end else begin
            r = h.px.red;
            g = h.px.green;
            b = h.px.blue;
        end
        f = '0;
        f[0][0] = g[0];
        for (int s = 1; s < SLOTS; s++) begin
            f[0][s] = r[6-s];
        end
        f[1][0] = b[1];
        f[1][1] = b[0];
        for (int s = 2; s < SLOTS; s++) begin
            f[1][s] = g[7-s];
        end
        f[2][0] = h.px.den;
        f[2][1] = h.px.vsync;
        f[2][2] = h.px.hsync;
        for (int s = 3; s < SLOTS; s++) begin
            f[2][s] = b[8-s];
        end
        f[3][0] = 1'b0;
        f[3][1] = b[7];
        f[3][2] = b[6];
        f[3][3] = g[7];
        f[3][4] = g[6];
        f[3][5] = r[7];
        f[3][6] = r[6];
        if (uses_three_lanes(h.map)) begin
            f[3] = '0;
        end
        return f;
    endfunction

endpackage

// File: rtl/lvds_pix_capture.sv
`timescale 1ns/100ps
// Pixel-domain holding register: samples pixel and layout select on every
// rising pixel-clock edge. Assumes inputs are stable around that edge.
module lvds_pix_capture
    import lvds_ser_pkg::*;
(
    input  logic   pix_clk,
    input  logic   rst_n,
    input  pixel_t px_i,
    input  map_e   map_i,
    output held_t  held_o
);

    // Capture one pixel with its layout per pixel period.
    always_ff @(posedge pix_clk) begin
        if (!rst_n) begin
            held_o <= '0;
        end else begin
            held_o.px  <= px_i;
            held_o.map <= map_i;
        end
    end

endmodule

// File: rtl/lvds_slot_timer.sv
`timescale 1ns/100ps
// Bit-domain slot counter. Counts 0..SLOTS-1 and signals the load edge at
// the last slot. Assumes reset is released on an edge that lines up with a
// pixel edge, so slot 0 then follows on the next such edge.
module lvds_slot_timer
    import lvds_ser_pkg::*;
(
    input  logic              bit_clk,
    input  logic              rst_n,
    output logic [SLOT_W-1:0] slot_o,
    output logic              load_o,
    output logic              running_o
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    assign load_o = (slot_o == LAST_SLOT);

    // Advance the slot index and wrap at the pixel boundary.
    always_ff @(posedge bit_clk) begin
        if (!rst_n) begin
            slot_o <= '0;
        end else if (load_o) begin
            slot_o <= '0;
        end else begin
            slot_o <= slot_o + SLOT_W'(1);
        end
    end

    // Mark the stream valid from the first load after reset.
    always_ff @(posedge bit_clk) begin
        if (!rst_n) begin
            running_o <= 1'b0;
        end else if (load_o) begin
            running_o <= 1'b1;
        end
    end

    p_slot_bound_r10: assert property (@(posedge bit_clk) disable iff (!rst_n)
        slot_o <= LAST_SLOT);

    p_slot_step_r10: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (slot_o != LAST_SLOT) |=> (slot_o == $past(slot_o) + SLOT_W'(1)));

    p_slot_wrap_r10: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (slot_o == LAST_SLOT) |=> (slot_o == '0) && running_o);

endmodule

// File: rtl/lvds_lane_shifter.sv
`timescale 1ns/100ps
// One serial lane: loads a seven-slot word at the pixel boundary and
// presents slot 0 at once, then one slot per bit edge. Output is registered.
module lvds_lane_shifter #(
    parameter int WIDTH = 7
) (
    input  logic             bit_clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] word_i,
    output logic             bit_o
);

    logic [WIDTH-2:0] rest_q;

    // Present the next slot and shift the remaining slots down.
    always_ff @(posedge bit_clk) begin
        if (!rst_n) begin
            bit_o  <= 1'b0;
            rest_q <= '0;
        end else if (load_i) begin
            bit_o  <= word_i[0];
            rest_q <= word_i[WIDTH-1:1];
        end else begin
            bit_o  <= rest_q[0];
            rest_q <= {1'b0, rest_q[WIDTH-2:1]};
        end
    end

endmodule

// File: rtl/lvds_pixel_serializer.sv
`timescale 1ns/100ps
// Seven-slot pixel serializer: holds a pixel per pixel clock, maps it to a
// slot layout chosen by mode_i and shifts it out on the data lanes beside a
// fixed clock-lane pattern. Assumes bit_clk is seven times pix_clk with
// aligned rising edges and that rst_n is released on a shared edge.
module lvds_pixel_serializer
    import lvds_ser_pkg::*;
(
    input  logic                  bit_clk,
    input  logic                  pix_clk,
    input  logic                  rst_n,
    input  logic [COLOR_W-1:0]    red_i,
    input  logic [COLOR_W-1:0]    green_i,
    input  logic [COLOR_W-1:0]    blue_i,
    input  logic                  hsync_i,
    input  logic                  vsync_i,
    input  logic                  de_i,
    input  logic [1:0]            mode_i,
    output logic [DATA_LANES-1:0] lane_o,
    output logic                  clk_lane_o
);

    pixel_t            px_in;
    held_t             held_q;
    frame_t            frame;
    logic [SLOT_W-1:0] slot_q;
    logic              load;
    logic              running;
    map_e              live_map_q;

    assign px_in = '{red: red_i, green: green_i, blue: blue_i,
                     hsync: hsync_i, vsync: vsync_i, den: de_i};

    lvds_pix_capture u_capture (
        .pix_clk (pix_clk),
        .rst_n   (rst_n),
        .px_i    (px_in),
        .map_i   (map_e'(mode_i)),
        .held_o  (held_q)
    );

    lvds_slot_timer u_timer (
        .bit_clk   (bit_clk),
        .rst_n     (rst_n),
        .slot_o    (slot_q),
        .load_o    (load),
        .running_o (running)
    );

    assign frame = build_frame(held_q);

    // Remember the layout of the pixel now on the lanes.
    always_ff @(posedge bit_clk) begin
        if (!rst_n) begin
            live_map_q <= MAP_NARROW;
        end else if (load) begin
            live_map_q <= held_q.map;
        end
    end

    for (genvar i = 0; i < DATA_LANES; i++) begin : g_lane
        lvds_lane_shifter #(.WIDTH(SLOTS)) u_shift (
            .bit_clk (bit_clk),
            .rst_n   (rst_n),
            .load_i  (load),
            .word_i  (frame[i]),
            .bit_o   (lane_o[i])
        );
    end

    lvds_lane_shifter #(.WIDTH(SLOTS)) u_clk_shift (
        .bit_clk (bit_clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .word_i  (CLK_PATTERN),
        .bit_o   (clk_lane_o)
    );

    p_idle_low_r1: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !running |-> (lane_o == '0) && !clk_lane_o);

    p_clk_shape_r2: assert property (@(posedge bit_clk) disable iff (!rst_n)
        running |-> (clk_lane_o == CLK_PATTERN[slot_q]));

    p_lane3_quiet_r4: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (running && uses_three_lanes(live_map_q)) |-> !lane_o[3]);

    p_ctl3_low_r7: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (running && slot_q == '0) |-> !lane_o[3]);

    p_map_hold_r9: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !load |=> $stable(live_map_q));

endmodule

// File: tb/lvds_pixel_serializer_test.sv
`timescale 1ns/100ps
module lvds_pixel_serializer_test;

    localparam int BIT_PERIOD_NS = 2;
    localparam int RATIO         = 7;

    logic       bit_clk = 1'b0;
    logic       pix_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic [7:0] red_i = '0, green_i = '0, blue_i = '0;
    logic       hsync_i = 1'b0, vsync_i = 1'b0, de_i = 1'b0;
    logic [1:0] mode_i = '0;
    logic [3:0] lane_o;
    logic       clk_lane_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    string phase = "R1";

    lvds_pixel_serializer uut (
        .bit_clk(bit_clk), .pix_clk(pix_clk), .rst_n(rst_n),
        .red_i(red_i), .green_i(green_i), .blue_i(blue_i),
        .hsync_i(hsync_i), .vsync_i(vsync_i), .de_i(de_i),
        .mode_i(mode_i), .lane_o(lane_o), .clk_lane_o(clk_lane_o)
    );

    // Both clocks from one counter so every 7th bit rise is a pixel rise.
    int half_cnt = 0;
    initial begin
        forever begin
            #(BIT_PERIOD_NS / 2.0);
            bit_clk = ~bit_clk;
            half_cnt++;
            if (half_cnt % RATIO == 0) pix_clk = ~pix_clk;
        end
    end

    // Reference layouts, slot 0 in the MSB of each 7-bit vector.
    function automatic logic [6:0] ref_lane(input logic [28:0] p, input int ln);
        logic [7:0] r, g, b;
        logic hs, vs, de;
        int md;
        r = p[28:21]; g = p[20:13]; b = p[12:5];
        hs = p[4]; vs = p[3]; de = p[2]; md = int'(p[1:0]);
        if (md == 1) begin
            case (ln)
                0: return {g[2], r[7], r[6], r[5], r[4], r[3], r[2]};
                1: return {b[3], b[2], g[7], g[6], g[5], g[4], g[3]};
                2: return {de, vs, hs, b[7], b[6], b[5], b[4]};
                default: return {1'b0, b[1], b[0], g[1], g[0], r[1], r[0]};
            endcase
        end
        case (ln)
            0: return {g[0], r[5], r[4], r[3], r[2], r[1], r[0]};
            1: return {b[1], b[0], g[5], g[4], g[3], g[2], g[1]};
            2: return {de, vs, hs, b[5], b[4], b[3], b[2]};
            default: return (md == 2) ? {1'b0, b[7], b[6], g[7], g[6], r[7], r[6]} : 7'b0;
        endcase
    endfunction

    logic [28:0] pend[$];
    logic [28:0] cur;
    int          nbit = 0;
    bit          exp_run = 0;
    logic [3:0]  exp_lane = '0;
    logic        exp_clk = 1'b0;
    int          exp_slot = 0;

    // Cycle model: pop the pixel to send, then push the one sampled now.
    always @(posedge bit_clk) begin
        if (!rst_n) begin
            nbit = 0;
            exp_run = 0;
            pend.delete();
            pend.push_back('0);
            exp_lane = '0;
            exp_clk = 1'b0;
        end else begin
            nbit++;
            if (nbit % RATIO == 0) begin
                cur = pend.pop_front();
                pend.push_back({red_i, green_i, blue_i, hsync_i, vsync_i, de_i, mode_i});
                exp_run = 1;
            end
            exp_slot = nbit % RATIO;
            if (exp_run) begin
                for (int l = 0; l < 4; l++) exp_lane[l] = ref_lane(cur, l)[6-exp_slot];
                exp_clk = (exp_slot < 2) || (exp_slot > 4);
            end else begin
                exp_lane = '0;
                exp_clk = 1'b0;
            end
        end
    end

    function automatic string tag_for(input int ln);
        int md;
        md = int'(cur[1:0]);
        if (!exp_run) return "R1";
        if (ln == 4) return "R2";
        if (ln == 3 && (md == 0 || md == 3)) return "R4";
        if (exp_slot < 3 && ln >= 2) return "R7";
        if (md == 1) return "R5";
        if (md == 2) return "R6";
        return "R3";
    endfunction

    // Compare every bit period away from the active edge.
    always @(negedge bit_clk) begin
        if (done) begin
            // idle
        end else begin
            checks++;
            for (int l = 0; l < 4; l++) begin
                if (lane_o[l] !== exp_lane[l]) begin
                    errors++;
                    $display("FAIL %s lane %0d slot %0d actual %b expected %b (phase %s, R8 timing)",
                             tag_for(l), l, exp_slot, lane_o[l], exp_lane[l], phase);
                end
            end
            if (clk_lane_o !== exp_clk) begin
                errors++;
                $display("FAIL %s clock lane slot %0d actual %b expected %b (phase %s)",
                         tag_for(4), exp_slot, clk_lane_o, exp_clk, phase);
            end
        end
    end

    int seed = 32'h1234_5678;
    function automatic int next_rand(input int s);
        return s * 1103515245 + 12345;
    endfunction

    task automatic drive_random(input logic [1:0] md);
        seed = next_rand(seed); red_i   = seed[23:16];
        seed = next_rand(seed); green_i = seed[23:16];
        seed = next_rand(seed); blue_i  = seed[23:16];
        hsync_i = seed[10]; vsync_i = seed[11]; de_i = seed[12];
        mode_i = md;
    endtask

    task automatic send(input logic [1:0] md);
        @(negedge pix_clk);
        drive_random(md);
    endtask

    // R9: inputs wander between pixel edges; only the value at the edge counts.
    task automatic send_wandering(input logic [1:0] md);
        @(negedge pix_clk);
        drive_random(~md);
        @(negedge bit_clk);
        drive_random(md + 2'd1);
        @(negedge bit_clk);
        drive_random(md);
    endtask

    task automatic release_reset;
        @(posedge pix_clk);
        #0.5;
        rst_n = 1'b1;
    endtask

    task automatic enter_reset;
        @(posedge pix_clk);
        #0.5;
        rst_n = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge pix_clk);
        release_reset();
        phase = "R3";
        repeat (20) send(2'd0);
        red_i = 8'hFF; green_i = 8'hFF; blue_i = 8'hFF;
        phase = "R4";
        repeat (6) send(2'd3);
        phase = "R5";
        repeat (20) send(2'd1);
        phase = "R6";
        repeat (20) send(2'd2);
        phase = "R8";
        for (int k = 0; k < 8; k++) begin
            @(negedge pix_clk);
            red_i = 8'h01 << k; green_i = 8'h80 >> k; blue_i = 8'h01 << k;
            hsync_i = k[0]; vsync_i = k[1]; de_i = k[2];
            mode_i = 2'(k % 3);
        end
        phase = "R9";
        for (int k = 0; k < 24; k++) send_wandering(2'(k % 4));
        phase = "R10";
        enter_reset();
        repeat (2) @(posedge pix_clk);
        release_reset();
        repeat (12) send(2'(seed[3:2]));
        phase = "R7";
        for (int k = 0; k < 8; k++) begin
            @(negedge pix_clk);
            red_i = '0; green_i = '0; blue_i = '0;
            hsync_i = k[0]; vsync_i = k[1]; de_i = k[2]; mode_i = 2'd1;
        end
        repeat (3) @(posedge pix_clk);
        @(negedge bit_clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * BIT_PERIOD_NS);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired in phase %s actual running expected finished", phase);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule